// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a handful of recent virtual-to-physical page translations in front of a page table walker. Each cycle a requester can present a virtual page number, a page offset and an access kind. The page number is compared against every stored entry at once. On a match the physical address, made of the stored frame number followed by the offset, is returned combinationally in the same cycle. When nothing matches, a walk request is raised.

The walker answers with a refill. The refill either installs a translation or reports a page fault. A faulting walk installs nothing, because only resident pages are kept. The requester then retries the access.

Each entry keeps three status flags: valid, dirty and referenced. Hits update these flags. A purge input, used on a process switch, empties the whole buffer. When every slot is occupied, a free-running pseudo-random sequence picks the entry to replace, and the most recently hit entry is always spared.

Top module: `xlat_buf`

## Requirements
- R1: After synchronous reset every entry is invalid, so any lookup reports `hit`=0.
- R2: A lookup whose page number matches a valid entry raises `hit` in the same cycle. In that cycle `pa` equals {stored frame number, `lk_off`} (frame in the upper bits) and `hit_idx` gives the entry's slot.
- R3: `miss` is 1 exactly when `lk_valid` is 1 and no valid entry matches. `miss` is 0 whenever `lk_valid` is 0.
- R4: A refill with `fill_fault`=0 installs the translation, and a later lookup of that page number hits with the refilled frame.
- R5: A refill with `fill_fault`=1 installs nothing, and a later lookup of that page number misses.
- R6: While free slots remain, a refill takes the lowest-numbered invalid slot.
- R7: Any hit sets the entry's referenced flag. A write hit (`lk_write`=1) also sets its dirty flag, and a read hit leaves dirty unchanged. `hit_ref` and `hit_dirty` show the entry's flags as they stood before the current access updates them.
- R8: A freshly installed entry starts with dirty=0 and referenced=0.
- R9: When the buffer is full, a refill replaces exactly one entry, and that entry is never the most recently hit one.
- R10: `purge` invalidates every entry at the next clock edge. A refill in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_off | input | OFF_W | Page offset carried into the physical address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| hit | output | 1 | Lookup matched a valid entry |
| miss | output | 1 | Walk request: lookup present but unmatched |
| pa | output | PFN_W+OFF_W | Physical address {frame, offset} |
| hit_idx | output | $clog2(ENTRIES) | Slot of the matching entry |
| hit_dirty | output | 1 | Dirty flag of the matching entry before update |
| hit_ref | output | 1 | Referenced flag of the matching entry before update |
| fill_valid | input | 1 | Walker response present |
| fill_fault | input | 1 | Walk ended in a page fault; nothing is installed |
| fill_vpn | input | VPN_W | Page number of the walked translation |
| fill_pfn | input | PFN_W | Frame number of the walked translation |
| purge | input | 1 | Invalidate all entries (process switch) |

## Verification
The bench builds the buffer with 8 entries, 10-bit page and frame numbers and a 4-bit offset. With these sizes every slot can be filled, inspected and displaced many times within a short run, and every offset value can be swept through each slot's address path. For every possible last-hit slot, the bench fills the buffer, hits that slot and forces a replacement. It then checks that the hit slot survives and that exactly one other translation is gone, whatever the pseudo-random sequence chose.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int RND_W = 8;
    localparam logic [RND_W-1:0] RND_MASK = 8'hB8;
    localparam logic [RND_W-1:0] RND_SEED = 8'h01;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic refd;
    } flags_t;

    localparam flags_t FLAGS_EMPTY = '{valid: 1'b0, dirty: 1'b0, refd: 1'b0};
    localparam flags_t FLAGS_FRESH = '{valid: 1'b1, dirty: 1'b0, refd: 1'b0};

    function automatic logic [RND_W-1:0] rnd_step(input logic [RND_W-1:0] s);
        logic [RND_W-1:0] sh;
        sh = s >> 1;
        return s[0] ? (sh ^ RND_MASK) : sh;
    endfunction

    function automatic flags_t flags_on_hit(input flags_t f, input acc_e kind);
        flags_t r;
        r = f;
        r.refd = 1'b1;
        if (kind == ACC_WRITE) r.dirty = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/xlat_rnd.sv
module xlat_rnd
    import xlat_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] rnd_idx
);
    logic [RND_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RND_SEED;
        else     state_q <= rnd_step(state_q);
    end

    assign rnd_idx = state_q[IDX_W-1:0];

    assert_state_nonzero: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state_q != '0);
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [VPN_W-1:0]   key,
    input  logic [VPN_W-1:0]   tags [ENTRIES],
    input  logic [ENTRIES-1:0] valids,
    output logic [ENTRIES-1:0] match_vec,
    output logic               match_any,
    output logic [IDX_W-1:0]   match_idx
);
    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match_vec[g] = valids[g] && (tags[g] == key);
        end
    endgenerate

    assign match_any = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] valids,
    input  logic [IDX_W-1:0]   rnd_idx,
    input  logic               last_valid,
    input  logic [IDX_W-1:0]   last_idx,
    output logic [IDX_W-1:0]   victim
);
    logic             have_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rnd_pick;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valids[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
    end

    assign rnd_pick = (last_valid && (rnd_idx == last_idx)) ? rnd_idx + 1'b1 : rnd_idx;
    assign victim   = have_free ? free_idx : rnd_pick;
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int PA_W   = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [OFF_W-1:0] lk_off,
    input  logic             lk_write,
    output logic             hit,
    output logic             miss,
    output logic [PA_W-1:0]  pa,
    output logic [IDX_W-1:0] hit_idx,
    output logic             hit_dirty,
    output logic             hit_ref,
    input  logic             fill_valid,
    input  logic             fill_fault,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             purge
);
    logic [VPN_W-1:0]   tag_q   [ENTRIES];
    logic [PFN_W-1:0]   pfn_q   [ENTRIES];
    flags_t             flags_q [ENTRIES];
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] match_vec;
    logic               match_any;
    logic [IDX_W-1:0]   match_idx;
    logic [IDX_W-1:0]   rnd_idx;
    logic [IDX_W-1:0]   victim;
    logic               last_valid_q;
    logic [IDX_W-1:0]   last_idx_q;
    logic               install;
    logic               hit_upd;
    acc_e               kind;

    genvar g;
    generate
        for (g = 0; g < ENTRIES; g++) begin : g_vld
            assign valid_vec[g] = flags_q[g].valid;
        end
    endgenerate

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
        .key      (lk_vpn),
        .tags     (tag_q),
        .valids   (valid_vec),
        .match_vec(match_vec),
        .match_any(match_any),
        .match_idx(match_idx)
    );

    xlat_rnd #(.IDX_W(IDX_W)) u_rnd (
        .clk    (clk),
        .rst    (rst),
        .rnd_idx(rnd_idx)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .valids    (valid_vec),
        .rnd_idx   (rnd_idx),
        .last_valid(last_valid_q),
        .last_idx  (last_idx_q),
        .victim    (victim)
    );

    assign kind      = lk_write ? ACC_WRITE : ACC_READ;
    assign hit       = lk_valid && match_any;
    assign miss      = lk_valid && !match_any;
    assign hit_idx   = match_idx;
    assign pa        = {pfn_q[match_idx], lk_off};
    assign hit_dirty = flags_q[match_idx].dirty;
    assign hit_ref   = flags_q[match_idx].refd;
    assign install   = fill_valid && !fill_fault && !purge;
    assign hit_upd   = hit && !purge;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_valid_q <= 1'b0;
            last_idx_q   <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                flags_q[i] <= FLAGS_EMPTY;
                tag_q[i]   <= '0;
                pfn_q[i]   <= '0;
            end
        end else if (purge) begin
            last_valid_q <= 1'b0;
            for (int i = 0; i < ENTRIES; i++) flags_q[i] <= FLAGS_EMPTY;
        end else begin
            if (hit_upd) begin
                last_valid_q       <= 1'b1;
                last_idx_q         <= match_idx;
                flags_q[match_idx] <= flags_on_hit(flags_q[match_idx], kind);
            end
            if (install) begin
                tag_q[victim]   <= fill_vpn;
                pfn_q[victim]   <= fill_pfn;
                flags_q[victim] <= FLAGS_FRESH;
            end
        end
    end

    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match_vec));

    assert_fill_lands_R4: assert property (@(posedge clk) disable iff (rst)
        install |=> valid_vec[$past(victim)]);

    assert_hit_marks_ref_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_upd && !(install && victim == match_idx)) |=> flags_q[$past(match_idx)].refd);

    assert_write_marks_dirty_R7: assert property (@(posedge clk) disable iff (rst)
        (hit_upd && lk_write && !(install && victim == match_idx))
            |=> flags_q[$past(match_idx)].dirty);

    assert_spare_last_R9: assert property (@(posedge clk) disable iff (rst)
        (install && (&valid_vec) && last_valid_q) |-> victim != last_idx_q);

    assert_purge_empties_R10: assert property (@(posedge clk) disable iff (rst)
        purge |=> valid_vec == '0);
endmodule

// File: tb/sim_xlat_buf.sv
module sim_xlat_buf;
    localparam int E  = 8;
    localparam int VW = 10;
    localparam int PW = 10;
    localparam int OW = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_valid = 1'b0, lk_write = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [OW-1:0] lk_off = '0;
    logic hit, miss, hit_dirty, hit_ref;
    logic [PW+OW-1:0] pa;
    logic [IW-1:0] hit_idx;
    logic fill_valid = 1'b0, fill_fault = 1'b0, purge = 1'b0;
    logic [VW-1:0] fill_vpn = '0;
    logic [PW-1:0] fill_pfn = '0;

    int checks = 0;
    int fails  = 0;

    logic r_hit, r_miss, r_d, r_r;
    logic [PW+OW-1:0] r_pa;
    logic [IW-1:0] r_idx;

    always #5 clk = ~clk;

    xlat_buf #(.ENTRIES(E), .VPN_W(VW), .PFN_W(PW), .OFF_W(OW)) u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_off(lk_off),
        .lk_write(lk_write), .hit(hit), .miss(miss), .pa(pa), .hit_idx(hit_idx),
        .hit_dirty(hit_dirty), .hit_ref(hit_ref), .fill_valid(fill_valid),
        .fill_fault(fill_fault), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .purge(purge)
    );

    function automatic logic [PW-1:0] pfn_of(input int v);
        return PW'((v * 37 + 11) % (1 << PW));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic look(input int v, input int off, input bit wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = VW'(v); lk_off = OW'(off); lk_write = wr;
        #2;
        r_hit = hit; r_miss = miss; r_pa = pa; r_idx = hit_idx; r_d = hit_dirty; r_r = hit_ref;
        @(posedge clk); #1;
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic refill(input int v, input bit fault, input bit with_purge);
        @(negedge clk);
        fill_valid = 1'b1; fill_fault = fault; fill_vpn = VW'(v); fill_pfn = pfn_of(v);
        purge = with_purge;
        @(posedge clk); #1;
        fill_valid = 1'b0; fill_fault = 1'b0; purge = 1'b0;
    endtask

    task automatic do_purge();
        @(negedge clk); purge = 1'b1;
        @(posedge clk); #1; purge = 1'b0;
    endtask

    task automatic fill_all(input int base);
        for (int i = 0; i < E; i++) refill(base + i, 1'b0, 1'b0);
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 / R3: empty after reset
        for (int v = 0; v < 16; v++) begin
            look(v * 61, 0, 1'b0);
            chk(r_hit == 1'b0, "R1", "hit after reset", r_hit, 0);
            chk(r_miss == 1'b1, "R3", "miss after reset", r_miss, 1);
        end
        @(negedge clk); lk_valid = 1'b0; #2;
        chk(miss == 1'b0, "R3", "miss with no request", miss, 0);

        // R6 / R8 / R4: fill order, fresh flags
        for (int i = 0; i < E; i++) begin
            refill(100 + i, 1'b0, 1'b0);
            look(100 + i, 5, 1'b0);
            chk(r_hit == 1'b1, "R4", "hit after refill", r_hit, 1);
            chk(r_idx == IW'(i), "R6", "slot order", r_idx, i);
            chk(r_d == 1'b0 && r_r == 1'b0, "R8", "fresh flags", {r_d, r_r}, 0);
        end
        // R3: miss on full buffer for absent page
        look(999, 0, 1'b0);
        chk(r_miss == 1'b1 && r_hit == 1'b0, "R3", "miss absent page", r_miss, 1);

        // R2: offset sweep through every slot
        for (int i = 0; i < E; i++) begin
            for (int o = 0; o < (1 << OW); o++) begin
                look(100 + i, o, 1'b0);
                chk(r_hit && r_pa == {pfn_of(100 + i), OW'(o)}, "R2", "physical address",
                    r_pa, {pfn_of(100 + i), OW'(o)});
            end
        end

        // R7: flag updates
        look(100 + 3, 0, 1'b0);
        chk(r_r == 1'b1 && r_d == 1'b0, "R7", "read keeps clean", {r_d, r_r}, 1);
        look(100 + 3, 0, 1'b1);
        look(100 + 3, 0, 1'b0);
        chk(r_d == 1'b1 && r_r == 1'b1, "R7", "write sets dirty", {r_d, r_r}, 3);

        // R10: purge, then purge with concurrent refill
        do_purge();
        for (int i = 0; i < E; i++) begin
            look(100 + i, 0, 1'b0);
            chk(r_hit == 1'b0, "R10", "entry after purge", r_hit, 0);
        end
        refill(321, 1'b0, 1'b1);
        look(321, 0, 1'b0);
        chk(r_hit == 1'b0, "R10", "refill during purge", r_hit, 0);

        // R5: faulting walk installs nothing
        refill(222, 1'b1, 1'b0);
        look(222, 0, 1'b0);
        chk(r_hit == 1'b0 && r_miss == 1'b1, "R5", "fault refill", r_hit, 0);
        refill(223, 1'b0, 1'b0);
        look(223, 0, 1'b0);
        chk(r_idx == 0, "R6", "slot 0 after fault", r_idx, 0);

        // R9: replacement spares the last hit slot, for every slot
        for (int k = 0; k < E; k++) begin
            int cnt;
            do_purge();
            fill_all(20);
            look(20 + k, 0, 1'b0);
            refill(900 + k, 1'b0, 1'b0);
            look(900 + k, 2, 1'b0);
            chk(r_hit && r_pa == {pfn_of(900 + k), OW'(2)}, "R4", "replacement hit", r_pa,
                {pfn_of(900 + k), OW'(2)});
            chk(r_idx != IW'(k), "R9", "victim slot", r_idx, k);
            look(20 + k, 0, 1'b0);
            chk(r_hit && r_idx == IW'(k), "R9", "last hit kept", r_idx, k);
            cnt = 0;
            for (int j = 0; j < E; j++) begin
                if (j != k) begin
                    look(20 + j, 0, 1'b0);
                    if (r_hit) cnt++;
                end
            end
            chk(cnt == E - 2, "R9", "survivors", cnt, E - 2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule